// File: doc/BRIEF.md
# Self-timed ternary receive FIFO

This block is the receiving end of a point-to-point link whose transmitter and receiver share one frequency but not one phase. Every symbol on the single incoming line is a three-level value carried as a 2-bit code. Each data value (false or true) is followed by a spacer, so the line carries its own strobe and needs no separate request wire. A chain of self-timed elements takes in the arriving symbols at whatever phase they come and passes them forward. Each element is evaluated on a fast sampling clock, which stands in for the asynchronous element rule. The receiver's own clock then removes one value per period at the far end.

After reset the chain is empty and the receive side is held off. A detector watches the line for its first move from spacer to data. That event is carried through a short synchronizer stepped by the receive clock. Only then is the gated receive clock let through, starting at a low phase. It acts as the acknowledge of the last element, and on each of its rising edges a retiming register decodes the value at the end of the chain back to one binary bit with a one-cycle strobe. A sticky error flag records any read that finds a spacer or the illegal code instead of data.

Top module: `tern_rx_fifo`

## Requirements
- R1: Line codes are 2'b00 spacer, 2'b01 false, 2'b10 true and 2'b11 illegal; the illegal code counts as data for flow control. A read of true gives bit_o = 1 and a read of false gives bit_o = 0.
- R2: An element updates only when the data/spacer status of its input differs from the status of the element after it; for the last element, the acknowledge stands in for that status. As a result, an element's output only ever swings between a spacer and a data value and never goes from one data value straight to another.
- R3: With the transmitter sending one datum per receive period (data for half the period, spacer for the other half), every bit is delivered once, in order and without error, for every phase offset of the receive clock in steps of one sampling cycle. The chain has STAGES elements, 9 by default.
- R4: While the line has carried only spacers, no read happens, however long the receive clock has been running.
- R5: First-data detection passes through SYNC_DEPTH flops (default 2) stepped by receive clock rising edges, and the gate then opens during a low phase. With the default depth, the first strobe comes between 2 and 5 receive periods after the first datum appears on the line.
- R6: The last element takes a new data value only while the gated receive clock is low, and a rising edge of that clock reads it.
- R7: bit_vld_o is a one-cycle pulse, one per data value read. A stream of N values with no illegal code gives exactly N pulses.
- R8: Reset clears every element to spacer, closes the receive gate, and drives bit_o, bit_vld_o and err_o low.
- R9: err_o is set by a read that finds a spacer or the illegal code, does not pulse bit_vld_o for that read, and stays set until reset. Reads of valid data before that leave err_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock that evaluates the element chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Incoming ternary symbol code |
| rxclk_i | input | 1 | Free-running receive clock, sampled in the clk domain |
| bit_o | output | 1 | Decoded binary value of the last read |
| bit_vld_o | output | 1 | One-cycle strobe marking a valid read |
| err_o | output | 1 | Sticky flag for a read that found no valid data |

## Verification
The hardest situation to reach from the ports is a chain at its fill limit with the receive clock's phase against the transmitter's. There a single lost or doubled symbol would shift the whole decoded stream. The bench sweeps every one-cycle phase offset of the receive clock against four bit patterns, so each alignment of the start-up synchronizer, and so each starting fill level, is visited. It then compares every decoded bit with the pattern formula. Underflow is forced by stopping the transmitter and letting the reader drain the chain, and a read of bad data is forced by putting the illegal code in one slot mid-stream.

// File: rtl/tern_rx_fifo.sv
module tern_rx_fifo #(
  parameter int STAGES     = 9,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_i,
  input  logic       rxclk_i,
  output logic       bit_o,
  output logic       bit_vld_o,
  output logic       err_o
);
  localparam int         LAST   = STAGES - 1;
  localparam int         QW     = 2 * STAGES;
  localparam logic [1:0] C_FALSE = 2'b01;
  localparam logic [1:0] C_TRUE  = 2'b10;

  logic [QW-1:0]         qv;
  logic [QW-1:0]         dv;
  logic [STAGES-1:0]     st, in_st, nx_st, take;
  logic [SYNC_DEPTH-1:0] sy;
  logic                  line_prev_st, arrived, rx_prev, gate_en, ack_prev;
  logic                  ack, rx_rise, run;

  assign dv      = {qv[QW-3:0], line_i};
  assign ack     = rxclk_i & gate_en;
  assign rx_rise = rxclk_i & ~rx_prev;
  assign run     = sy[SYNC_DEPTH-1];
  assign nx_st   = {ack, st[STAGES-1:1]};
  assign take    = in_st ^ nx_st;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign st[g]    = |qv[2*g +: 2];
    assign in_st[g] = |dv[2*g +: 2];

    p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (qv[2*g +: 2] != $past(qv[2*g +: 2])) |-> (st[g] != $past(st[g])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qv <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++)
        if (take[i]) qv[2*i +: 2] <= dv[2*i +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_st <= 1'b0;
      arrived      <= 1'b0;
      rx_prev      <= 1'b0;
      sy           <= '0;
      gate_en      <= 1'b0;
    end else begin
      line_prev_st <= |line_i;
      if ((|line_i) && !line_prev_st) arrived <= 1'b1;
      rx_prev <= rxclk_i;
      if (rx_rise) sy <= {sy[SYNC_DEPTH-2:0], arrived};
      if (!rxclk_i) gate_en <= run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev  <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      ack_prev  <= ack;
      bit_vld_o <= 1'b0;
      if (ack && !ack_prev) begin
        case (qv[2*LAST +: 2])
          C_TRUE:  begin bit_o <= 1'b1; bit_vld_o <= 1'b1; end
          C_FALSE: begin bit_o <= 1'b0; bit_vld_o <= 1'b1; end
          default: err_o <= 1'b1;
        endcase
      end
    end
  end

  p_no_early_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> arrived);

  p_last_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack) |-> !$rose(st[LAST]));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |=> !bit_vld_o);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: tb/tern_rx_fifo_test.sv
module tern_rx_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line = 2'b00;
  logic       rxclk = 1'b0;
  logic       bit_o, vld, err;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  tern_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .rxclk_i(rxclk),
    .bit_o(bit_o), .bit_vld_o(vld), .err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pat(int kind, int k, int ph);
    case (kind)
      0:       return bit'(k % 2);
      1:       return 1'b0;
      2:       return 1'b1;
      default: return bit'(((k * k * 7 + k * 3 + ph * 5) / 3) % 2);
    endcase
  endfunction

  task automatic run(int ph, int kind, int nbits, int idle, int bad_idx);
    int rcount, first, exp_idx, slot, k, total;
    rcount = 0; first = -1; exp_idx = 0;
    rst_n = 1'b0; line = 2'b00; rxclk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 strobe low in reset", vld, 0);
    chk("R8 error low in reset", err, 0);
    chk("R8 bit low in reset", bit_o, 0);
    rst_n = 1'b1;
    total = idle + nbits * 8 + 100;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (vld) begin
        if (first < 0) first = c - idle;
        if (bad_idx < 0 || exp_idx < bad_idx) chk("R9 no error before a bad read", err, 0);
        if (exp_idx == bad_idx) exp_idx++;
        chk("R3 R1 R2 R6 decoded bit", bit_o, pat(kind, exp_idx, ph));
        exp_idx++;
        rcount++;
      end
      if (c == idle) chk("R4 no read before first datum", rcount, 0);
      if (c == idle + nbits * 8 && bad_idx < 0) chk("R3 error clear while streaming", err, 0);
      rxclk = ((c + ph) % 8) < 4;
      if (c >= idle && c < idle + nbits * 8) begin
        slot = c - idle;
        k = slot / 8;
        if (slot % 8 < 4) line = (k == bad_idx) ? 2'b11 : (pat(kind, k, ph) ? 2'b10 : 2'b01);
        else line = 2'b00;
      end else begin
        line = 2'b00;
      end
    end
    chk("R7 read count", rcount, (bad_idx >= 0) ? nbits - 1 : nbits);
    chk("R9 sticky error after bad read or underflow", err, 1);
    chk("R5 start-up latency within 16..40 cycles", int'(first >= 16 && first <= 40), 1);
  endtask

  initial begin
    for (int ph = 0; ph < 8; ph++)
      for (int kind = 0; kind < 4; kind++)
        run(ph, kind, 40, 20, -1);
    run(3, 3, 40, 300, -1);
    run(0, 0, 30, 20, 10);
    run(5, 3, 30, 20, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule